// File: doc/BRIEF.md
# Software-Priority Nested Interrupt Controller

This block arbitrates a set of maskable interrupt sources. Each source carries a two-bit software priority that lives in byte-wide priority registers. The block also tracks the two-bit interrupt level at which the CPU is running. A pending source is offered to the CPU only when its priority is strictly above the running level. A source offered this way can therefore preempt a handler that is already running.

The CPU programs priorities over a simple register read/write bus. Sources raise and drop their pending flags through per-source set and clear lines. The CPU takes an offered request with an acknowledge pulse. On acknowledge, the block raises the running level to the priority of the granted source. A return pulse restores the level that the CPU popped from its stack. A non-maskable entry pulse (reset or trap) forces the top level.

Priority changes made while a handler is running need no special path. Raising a still-pending source above the current level wins arbitration again and re-enters it at once. Lowering a source leaves the running level as it is.

Top module: `sw_prio_intc`

## Requirements
- R1: After reset, every priority register reads FFh, the running level is 11, and no request is raised.
- R2: Source n owns bits 2*(n mod 4)+1 : 2*(n mod 4) of register n/4. Register bits with no source behind them (bits 7:4 of register 3 for 14 sources) always read 1 and ignore writes.
- R3: A write leaves a field unchanged when it carries the code 10 for that field. The other fields of the same write still update. For example, old value CFh written with 64h gives 44h. No field ever holds 10.
- R4: A source's pending flag is set by its set pulse and cleared only by its clear pulse. Set wins when both pulses arrive in the same cycle. A grant or an acknowledge does not clear the flag.
- R5: Levels rank from lowest to highest as 10, 01, 00, 11. A pending source is eligible only if its priority ranks strictly above the running level.
- R6: Among eligible sources, the one with the highest priority wins. Ties go to the lowest source index.
- R7: The request output rises one clock edge after a source becomes eligible. The request and its vector index then hold steady until acknowledge, return or entry.
- R8: An acknowledge while a request is raised does two things: it loads the running level with the priority the winner had when it was granted, and it drops the request. In any cycle with no acknowledge, return or entry, the running level holds.
- R9: A return pulse loads the running level from the popped-level input and drops any raised request. Arbitration against the new level follows on the next edge.
- R10: An entry pulse forces the running level to 11 and drops any raised request. It takes precedence over return and acknowledge.
- R11: Suppose a handler's source stays pending and its priority is raised above the running level. A new request for that source follows. If the priority is lowered instead, no request appears and the running level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | 2 | Priority register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the indexed register (combinational) |
| src_set_i | input | 14 | Per-source pending set pulses |
| src_clr_i | input | 14 | Per-source pending clear pulses |
| ack_i | input | 1 | CPU accepts the raised request |
| iret_i | input | 1 | Return from interrupt |
| iret_lvl_i | input | 2 | Level popped by the CPU on return |
| trap_i | input | 1 | Non-maskable reset/trap entry |
| irq_req_o | output | 1 | Request to the CPU |
| irq_vec_o | output | 4 | Index of the requesting source |
| cur_lvl_o | output | 2 | Running interrupt level |

## Verification
The bench builds the block with its default 14 sources and 8-bit registers. With these values the last register is only half populated, so the read-as-one bits are exercised. All four levels can also be reached, including the bottom level, which software can only enter through a return. Random register writes often carry the rejected code, which stresses field-wise rejection. Random set, clear, acknowledge, return and entry pulses make preemption, ties and stale grants collide with a reference model.

// File: rtl/sw_intc_pkg.sv
package sw_intc_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL0 = 2'b10;
  localparam lvl_t LVL1 = 2'b01;
  localparam lvl_t LVL2 = 2'b00;
  localparam lvl_t LVL3 = 2'b11;

  // ordinal rank of a level code, 0 = lowest
  function automatic logic [1:0] lvl_rank(lvl_t c);
    case (c)
      LVL0:    return 2'd0;
      LVL1:    return 2'd1;
      LVL2:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/sw_intc_prio_regs.sv
module sw_intc_prio_regs
  import sw_intc_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output lvl_t [NUM_SRC-1:0]     prio_o
);
  localparam int FPR = DATA_W / 2;

  lvl_t [NUM_SRC-1:0] prio_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
    localparam int REG_IDX = s / FPR;
    localparam int FLD_LO  = 2 * (s % FPR);

    lvl_t wr_fld;
    assign wr_fld = wdata_i[FLD_LO +: 2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[s] <= LVL3;
      else if (we_i && addr_i == ADDR_W'(REG_IDX) && wr_fld != LVL0)
        prio_q[s] <= wr_fld;  // level-0 code rejected per field
    end

    AST_FIELD_NOT_LVL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio_q[s] != LVL0) else $error("field holds rejected code"); // R3
  end

  always_comb begin
    rdata_o = '1;  // unbacked bits read as one
    for (int s = 0; s < NUM_SRC; s++) begin
      if (ADDR_W'(s / FPR) == addr_i) rdata_o[2*(s%FPR) +: 2] = prio_q[s];
    end
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/sw_intc_pend.sv
module sw_intc_pend #(
  parameter int NUM_SRC = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[s] <= 1'b0;
      else if (set_i[s]) pend_q[s] <= 1'b1;
      else if (clr_i[s]) pend_q[s] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_o & ~clr_i)) |=> ((pend_o & $past(pend_o & ~clr_i)) == $past(pend_o & ~clr_i)))
    else $error("pending lost without clear"); // R4
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)))
    else $error("set pulse not captured"); // R4
endmodule

// File: rtl/sw_intc_arbiter.sv
module sw_intc_arbiter
  import sw_intc_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  lvl_t [NUM_SRC-1:0] prio_i,
  input  lvl_t               cur_lvl_i,
  output logic               win_vld_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output lvl_t               win_lvl_o
);
  logic             vld;
  logic [IDX_W-1:0] idx;
  lvl_t             wlvl;
  logic [1:0]       best;

  // descending scan with >= leaves the lowest index on ties
  always_comb begin
    vld  = 1'b0;
    idx  = '0;
    wlvl = LVL3;
    best = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (pend_i[s] && lvl_rank(prio_i[s]) > lvl_rank(cur_lvl_i) &&
          (!vld || lvl_rank(prio_i[s]) >= best)) begin
        vld  = 1'b1;
        idx  = IDX_W'(s);
        wlvl = prio_i[s];
        best = lvl_rank(prio_i[s]);
      end
    end
  end

  assign win_vld_o = vld;
  assign win_idx_o = idx;
  assign win_lvl_o = wlvl;
endmodule

// File: rtl/sw_prio_intc.sv
module sw_prio_intc
  import sw_intc_pkg::*;
#(
  parameter int NUM_SRC = 14,
  parameter int DATA_W  = 8,
  localparam int FPR      = DATA_W / 2,
  localparam int NUM_REGS = (NUM_SRC + FPR - 1) / FPR,
  localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int VEC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [NUM_SRC-1:0] src_clr_i,
  input  logic               ack_i,
  input  logic               iret_i,
  input  logic [1:0]         iret_lvl_i,
  input  logic               trap_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [1:0]         cur_lvl_o
);
  lvl_t [NUM_SRC-1:0] prio;
  logic [NUM_SRC-1:0] pend;
  logic               win_vld;
  logic [VEC_W-1:0]   win_idx;
  lvl_t               win_lvl;

  lvl_t             cur_lvl_q;
  lvl_t             req_lvl_q;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  sw_intc_prio_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .prio_o  (prio)
  );

  sw_intc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set_i),
    .clr_i  (src_clr_i),
    .pend_o (pend)
  );

  sw_intc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(VEC_W)) u_arb (
    .pend_i    (pend),
    .prio_i    (prio),
    .cur_lvl_i (cur_lvl_q),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  // precedence: entry > return > acknowledge > new grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_lvl_q <= LVL3;
      req_lvl_q <= LVL3;
      req_q     <= 1'b0;
      vec_q     <= '0;
    end else if (trap_i) begin
      cur_lvl_q <= LVL3;
      req_q     <= 1'b0;
    end else if (iret_i) begin
      cur_lvl_q <= iret_lvl_i;
      req_q     <= 1'b0;
    end else if (req_q) begin
      if (ack_i) begin
        cur_lvl_q <= req_lvl_q;
        req_q     <= 1'b0;
      end
    end else if (win_vld) begin
      req_q     <= 1'b1;
      vec_q     <= win_idx;
      req_lvl_q <= win_lvl;
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;
  assign cur_lvl_o = cur_lvl_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && !ack_i && !trap_i && !iret_i |=> irq_req_o && $stable(irq_vec_o))
    else $error("request not held"); // R7
  AST_GRANT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> lvl_rank(req_lvl_q) > lvl_rank(cur_lvl_o))
    else $error("grant not above level"); // R5
  AST_ACK_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && ack_i && !trap_i && !iret_i |=> !irq_req_o && cur_lvl_o == $past(req_lvl_q))
    else $error("ack level wrong"); // R8
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i && !iret_i && !(irq_req_o && ack_i) |=> $stable(cur_lvl_o))
    else $error("level moved"); // R8
  AST_IRET_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iret_i && !trap_i |=> !irq_req_o && cur_lvl_o == $past(iret_lvl_i))
    else $error("return level wrong"); // R9
  AST_TRAP_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !irq_req_o && cur_lvl_o == LVL3)
    else $error("entry level wrong"); // R10
endmodule

// File: tb/sw_prio_intc_tb.sv
module sw_prio_intc_tb;
  localparam int NS = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NS-1:0] pset = '0, pclr = '0;
  logic ack = 1'b0, iret = 1'b0, trap = 1'b0;
  logic [1:0] iret_lvl = '0;
  logic req;
  logic [3:0] vec;
  logic [1:0] lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sw_prio_intc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_set_i(pset), .src_clr_i(pclr),
    .ack_i(ack), .iret_i(iret), .iret_lvl_i(iret_lvl), .trap_i(trap),
    .irq_req_o(req), .irq_vec_o(vec), .cur_lvl_o(lvl)
  );

  // reference model
  logic [1:0] m_prio [NS];
  logic [NS-1:0] m_pend;
  logic [1:0] m_lvl, m_rlvl;
  logic m_req;
  logic [3:0] m_vec;

  function automatic int rk(logic [1:0] c);
    case (c)
      2'b10: return 0;
      2'b01: return 1;
      2'b00: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] m_read(int a);
    logic [7:0] r = 8'hFF;
    for (int s = 0; s < NS; s++) if (s / 4 == a) r[2*(s%4) +: 2] = m_prio[s];
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int best = -1;
    int br = -1;
    for (int s = 0; s < NS; s++)
      if (m_pend[s] && rk(m_prio[s]) > rk(m_lvl) && rk(m_prio[s]) > br) begin
        best = s; br = rk(m_prio[s]);
      end
    if (trap) begin m_lvl = 2'b11; m_req = 0; end
    else if (iret) begin m_lvl = iret_lvl; m_req = 0; end
    else if (m_req) begin if (ack) begin m_lvl = m_rlvl; m_req = 0; end end
    else if (best >= 0) begin m_req = 1; m_vec = 4'(best); m_rlvl = m_prio[best]; end
    if (we)
      for (int s = 0; s < NS; s++)
        if (s / 4 == int'(addr) && wdata[2*(s%4) +: 2] != 2'b10) m_prio[s] = wdata[2*(s%4) +: 2];
    m_pend = (m_pend & ~pclr) | pset;
  endtask

  // inputs are set at a falling edge before the call
  task automatic step();
    #1;
    chk("R2 rdata", int'(rdata), int'(m_read(int'(addr))));
    model_edge();
    @(negedge clk);
    chk("R7 req", int'(req), int'(m_req));
    if (m_req) chk("R7 vec", int'(vec), int'(m_vec));
    chk("R8 lvl", int'(lvl), int'(m_lvl));
    we = 0; pset = '0; pclr = '0; ack = 0; iret = 0; trap = 0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    addr = 2'(a); wdata = d; we = 1; step();
  endtask

  task automatic rd_chk(string tag, int a, logic [7:0] exp);
    addr = 2'(a); #1;
    chk(tag, int'(rdata), int'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7311));
    for (int s = 0; s < NS; s++) m_prio[s] = 2'b11;
    m_pend = '0; m_lvl = 2'b11; m_rlvl = 2'b11; m_req = 0; m_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1 reset reg", a, 8'hFF);
    chk("R1 reset lvl", int'(lvl), 3);
    chk("R1 reset req", int'(req), 0);

    // R3 field-wise rejection of code 10
    wr(0, 8'hCF);
    wr(0, 8'h64);
    rd_chk("R3 CF<-64", 0, 8'h44);
    // R2 unbacked bits read as one
    wr(3, 8'h00);
    rd_chk("R2 reg3 high nibble", 3, 8'hF0);
    wr(0, 8'h55); wr(1, 8'h55); wr(2, 8'h55); wr(3, 8'h55);
    rd_chk("R2 reg3", 3, 8'hF5);

    // R5 equal level not eligible
    pset = NS'(1) << 5 | NS'(1) << 2; step();
    iret = 1; iret_lvl = 2'b01; step();
    step(); step();
    chk("R5 equal level blocked", int'(req), 0);
    // R9 return to level 0, R6 tie to lowest index
    iret = 1; iret_lvl = 2'b10; step();
    chk("R9 lvl after return", int'(lvl), 2);
    chk("R9 no req same edge", int'(req), 0);
    step();
    chk("R6 tie req", int'(req), 1);
    chk("R6 tie lowest idx", int'(vec), 2);
    // R7 held while a higher source appears
    pset = NS'(1) << 9; addr = 2; wdata = 8'h5D; we = 1; step();
    step();
    chk("R7 vec held", int'(vec), 2);
    // R8 ack loads granted level; R4 grant did not clear pending
    ack = 1; step();
    chk("R8 lvl after ack", int'(lvl), 1);
    step();
    chk("R6 higher prio wins", int'(vec), 9);
    ack = 1; step();
    chk("R8 lvl L3", int'(lvl), 3);
    // R11 lowering in service: nothing
    wr(2, 8'h55);
    step();
    chk("R11 lower no req", int'(req), 0);
    chk("R11 lower lvl kept", int'(lvl), 3);
    // R11 raising in service while pending: re-entry
    wr(2, 8'h51);
    iret = 1; iret_lvl = 2'b10; step();
    step();
    chk("R6 level 2 wins", int'(vec), 9);
    ack = 1; step();
    chk("R8 lvl L2", int'(lvl), 0);
    wr(2, 8'h5D);
    step();
    chk("R11 re-entry req", int'(req), 1);
    chk("R11 re-entry vec", int'(vec), 9);
    // R10 entry overrides
    trap = 1; ack = 1; step();
    chk("R10 lvl", int'(lvl), 3);
    chk("R10 req dropped", int'(req), 0);
    // R4 clear removes source; src2 still pending after its grant
    pclr = NS'(1) << 9; step();
    iret = 1; iret_lvl = 2'b10; step();
    step();
    chk("R4 cleared src skipped", int'(vec), 2);
    ack = 1; step();
    // R4 set wins over clear
    pset = NS'(1) << 0; pclr = NS'(1) << 0; step();
    iret = 1; iret_lvl = 2'b10; step();
    step();
    chk("R4 set wins", int'(vec), 0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      addr = 2'($urandom);
      we = ($urandom % 6) == 0;
      wdata = 8'($urandom);
      pset = NS'($urandom) & NS'($urandom) & NS'($urandom);
      pclr = NS'($urandom) & NS'($urandom) & NS'($urandom);
      ack = ($urandom % 3) == 0;
      iret = ($urandom % 12) == 0;
      iret_lvl = 2'($urandom);
      trap = ($urandom % 50) == 0;
      step();
    end
    finish_run();
  end
endmodule